// File: doc/BRIEF.md
# Mailbox Interrupt Logic

This block produces the port-to-port doorbell interrupts for a two-port shared memory. It watches the address, write strobe, read strobe and busy input of both ports. It keeps one flag per port, and each flag drives an active-low interrupt output. The message itself is stored in the shared RAM like any other word. This block only decides when each flag is set and when it is cleared.

Two words at the top of the address space are reserved as mailboxes. The topmost word (all address bits one) belongs to the right port. The word just below it (all ones except bit 0) belongs to the left port. A port rings its peer by writing the peer's word. A port acknowledges its own interrupt by reading its own word. A write made while the writing port's busy input is high is ignored by the flag logic.

Top module: `mbx_irq`

## Requirements
- R1: While rst_ni is low, and after it is released, both l_irq_no and r_irq_no are high (deasserted).
- R2: A left-port write (l_we_i=1) to address 2^ADDR_W-1 with l_busy_i=0 drives r_irq_no low in the cycle after the write strobe.
- R3: A right-port write (r_we_i=1) to address 2^ADDR_W-2 with r_busy_i=0 drives l_irq_no low in the cycle after the write strobe.
- R4: A right-port read (r_re_i=1) of address 2^ADDR_W-1 returns r_irq_no to high. A left-port read (l_re_i=1) of address 2^ADDR_W-2 returns l_irq_no to high. In both cases the change is visible in the next cycle.
- R5: A mailbox write made while the writing port's busy input is high leaves the peer's interrupt output unchanged.
- R6: If a set and a clear reach the same flag in one cycle, the set wins and the output is low afterwards.
- R7: These accesses leave both outputs unchanged: accesses to any other address, a port writing its own mailbox word, and a port reading its peer's mailbox word.
- R8: A flag holds its value until a qualifying clear. A repeated set keeps it low, and a clear of a flag that is already clear keeps it high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| l_addr_i | input | ADDR_W | Left port address |
| l_we_i | input | 1 | Left port write strobe |
| l_re_i | input | 1 | Left port read strobe |
| l_busy_i | input | 1 | Left port stalled by arbitration |
| r_addr_i | input | ADDR_W | Right port address |
| r_we_i | input | 1 | Right port write strobe |
| r_re_i | input | 1 | Right port read strobe |
| r_busy_i | input | 1 | Right port stalled by arbitration |
| l_irq_no | output | 1 | Interrupt toward the left port, active low |
| r_irq_no | output | 1 | Interrupt toward the right port, active low |

## Verification
The assertions check four rules on every cycle:
- a set always wins and lands one cycle later;
- an acknowledge without a set releases the flag;
- a flag with no event stays stable;
- a busy or foreign-address write never sets the peer's flag.

Only the bench's scenarios can show three things: the exact mailbox addresses for the default width, the pairing of each port with the correct peer word, and the reset value seen again after a mid-run reset.

// File: rtl/mbx_pkg.sv
package mbx_pkg;
  typedef struct packed {
    logic post;  // peer doorbell write accepted
    logic ack;   // own mailbox read
  } mbx_evt_t;

  localparam int unsigned NUM_PORTS = 2;
  localparam int unsigned PORT_L = 0;
  localparam int unsigned PORT_R = 1;
endpackage

// File: rtl/mbx_port_decode.sv
module mbx_port_decode
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 15,
  parameter logic [ADDR_W-1:0] POST_ADDR = '1,
  parameter logic [ADDR_W-1:0] ACK_ADDR = '1
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              we_i,
  input  logic              re_i,
  input  logic              busy_i,
  output mbx_evt_t          evt_o
);
  logic hit_post, hit_ack;

  assign hit_post   = (addr_i == POST_ADDR);
  assign hit_ack    = (addr_i == ACK_ADDR);
  // stalled writer must not ring the peer
  assign evt_o.post = we_i & ~busy_i & hit_post;
  assign evt_o.ack  = re_i & hit_ack;
endmodule

// File: rtl/mbx_flag.sv
module mbx_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic clr_i,
  output logic irq_no
);
  logic flag_q, flag_d;

  always_comb begin
    flag_d = flag_q;
    if (clr_i) flag_d = 1'b0;
    if (set_i) flag_d = 1'b1;  // set has priority
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_q <= 1'b0;
    else         flag_q <= flag_d;
  end

  assign irq_no = ~flag_q;

  AST_SET_WINS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    set_i |=> !irq_no);  // R6
  AST_ACK_RELEASES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i && !set_i |=> irq_no);  // R4
  AST_HOLD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !set_i && !clr_i |=> $stable(irq_no));  // R8
endmodule

// File: rtl/mbx_irq.sv
module mbx_irq
  import mbx_pkg::*;
#(
  parameter int unsigned ADDR_W = 15
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] l_addr_i,
  input  logic              l_we_i,
  input  logic              l_re_i,
  input  logic              l_busy_i,
  input  logic [ADDR_W-1:0] r_addr_i,
  input  logic              r_we_i,
  input  logic              r_re_i,
  input  logic              r_busy_i,
  output logic              l_irq_no,
  output logic              r_irq_no
);
  localparam logic [ADDR_W-1:0] SLOT_R = {ADDR_W{1'b1}};
  localparam logic [ADDR_W-1:0] SLOT_L = SLOT_R - 1'b1;

  logic [ADDR_W-1:0] addr   [NUM_PORTS];
  logic              we     [NUM_PORTS];
  logic              re     [NUM_PORTS];
  logic              busy   [NUM_PORTS];
  mbx_evt_t          evt    [NUM_PORTS];
  logic              irq_n  [NUM_PORTS];

  assign addr[PORT_L] = l_addr_i;
  assign we[PORT_L]   = l_we_i;
  assign re[PORT_L]   = l_re_i;
  assign busy[PORT_L] = l_busy_i;
  assign addr[PORT_R] = r_addr_i;
  assign we[PORT_R]   = r_we_i;
  assign re[PORT_R]   = r_re_i;
  assign busy[PORT_R] = r_busy_i;

  for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
    // each port posts to the peer slot and acknowledges its own
    localparam logic [ADDR_W-1:0] OWN  = (p == PORT_R) ? SLOT_R : SLOT_L;
    localparam logic [ADDR_W-1:0] PEER = (p == PORT_R) ? SLOT_L : SLOT_R;
    localparam int unsigned       OTHER = NUM_PORTS - 1 - p;

    mbx_port_decode #(
      .ADDR_W   (ADDR_W),
      .POST_ADDR(PEER),
      .ACK_ADDR (OWN)
    ) u_dec (
      .addr_i (addr[p]),
      .we_i   (we[p]),
      .re_i   (re[p]),
      .busy_i (busy[p]),
      .evt_o  (evt[p])
    );

    mbx_flag u_flag (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .set_i  (evt[OTHER].post),
      .clr_i  (evt[p].ack),
      .irq_no (irq_n[p])
    );
  end

  assign l_irq_no = irq_n[PORT_L];
  assign r_irq_no = irq_n[PORT_R];

  AST_BUSY_BLOCKS_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    l_we_i && l_busy_i && r_irq_no |=> r_irq_no);  // R5
  AST_BUSY_BLOCKS_L: assert property (@(posedge clk_i) disable iff (!rst_ni)
    r_we_i && r_busy_i && l_irq_no |=> l_irq_no);  // R5
  AST_FOREIGN_NO_SET_R: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(l_we_i && l_addr_i == SLOT_R) && r_irq_no |=> r_irq_no);  // R7
  AST_FOREIGN_NO_SET_L: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(r_we_i && r_addr_i == SLOT_L) && l_irq_no |=> l_irq_no);  // R7
endmodule

// File: tb/mbx_irq_test.sv
module mbx_irq_test;
  localparam int unsigned AW = 15;
  localparam logic [AW-1:0] T = 15'h7FFF;
  localparam logic [AW-1:0] N = 15'h7FFE;
  localparam logic [AW-1:0] O = 15'h0123;

  typedef struct packed {
    logic [AW-1:0] la; logic lw; logic lr; logic lb;
    logic [AW-1:0] ra; logic rw; logic rr; logic rb;
    logic exp_l;  logic exp_r;  logic [3:0] req;
  } vec_t;

  localparam int NV = 16;
  localparam vec_t VECS [NV] = '{
    '{T,1'b1,1'b0,1'b0, O,1'b0,1'b0,1'b0, 1'b1,1'b0, 4'd2},
    '{O,1'b1,1'b0,1'b0, O,1'b1,1'b1,1'b0, 1'b1,1'b0, 4'd7},
    '{O,1'b0,1'b0,1'b0, T,1'b0,1'b1,1'b0, 1'b1,1'b1, 4'd4},
    '{O,1'b0,1'b0,1'b0, N,1'b1,1'b0,1'b0, 1'b0,1'b1, 4'd3},
    '{N,1'b0,1'b1,1'b0, O,1'b0,1'b0,1'b0, 1'b1,1'b1, 4'd4},
    '{T,1'b1,1'b0,1'b1, O,1'b0,1'b0,1'b0, 1'b1,1'b1, 4'd5},
    '{O,1'b0,1'b0,1'b0, N,1'b1,1'b0,1'b1, 1'b1,1'b1, 4'd5},
    '{N,1'b1,1'b0,1'b0, T,1'b1,1'b0,1'b0, 1'b1,1'b1, 4'd7},
    '{T,1'b1,1'b0,1'b0, O,1'b0,1'b0,1'b0, 1'b1,1'b0, 4'd2},
    '{T,1'b0,1'b1,1'b0, N,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd7},
    '{T,1'b1,1'b0,1'b0, T,1'b0,1'b1,1'b0, 1'b1,1'b0, 4'd6},
    '{N,1'b0,1'b1,1'b0, N,1'b1,1'b0,1'b0, 1'b0,1'b0, 4'd6},
    '{O,1'b0,1'b0,1'b0, N,1'b1,1'b0,1'b0, 1'b0,1'b0, 4'd8},
    '{T,1'b0,1'b0,1'b1, T,1'b0,1'b0,1'b1, 1'b0,1'b0, 4'd8},
    '{N,1'b0,1'b1,1'b0, T,1'b0,1'b1,1'b0, 1'b1,1'b1, 4'd4},
    '{N,1'b0,1'b1,1'b0, T,1'b0,1'b1,1'b0, 1'b1,1'b1, 4'd8}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] l_addr = '0, r_addr = '0;
  logic l_we = 1'b0, l_re = 1'b0, l_busy = 1'b0;
  logic r_we = 1'b0, r_re = 1'b0, r_busy = 1'b0;
  logic l_irq_n, r_irq_n;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  mbx_irq #(.ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .l_addr_i(l_addr), .l_we_i(l_we), .l_re_i(l_re), .l_busy_i(l_busy),
    .r_addr_i(r_addr), .r_we_i(r_we), .r_re_i(r_re), .r_busy_i(r_busy),
    .l_irq_no(l_irq_n), .r_irq_no(r_irq_n)
  );

  task automatic check(input string tag, input logic act_l, act_r, exp_l, exp_r);
    checks++;
    if (act_l !== exp_l || act_r !== exp_r) begin
      fails++;
      $display("FAIL %s: l_irq_no=%b r_irq_no=%b expected %b %b",
               tag, act_l, act_r, exp_l, exp_r);
    end
  endtask

  task automatic drive(input vec_t v);
    l_addr = v.la; l_we = v.lw; l_re = v.lr; l_busy = v.lb;
    r_addr = v.ra; r_we = v.rw; r_re = v.rr; r_busy = v.rb;
  endtask

  task automatic idle();
    l_we = 1'b0; l_re = 1'b0; l_busy = 1'b0;
    r_we = 1'b0; r_re = 1'b0; r_busy = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 in reset", l_irq_n, r_irq_n, 1'b1, 1'b1);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", l_irq_n, r_irq_n, 1'b1, 1'b1);

    for (int i = 0; i < NV; i++) begin
      drive(VECS[i]);
      @(negedge clk);
      check($sformatf("R%0d vector %0d", VECS[i].req, i),
            l_irq_n, r_irq_n, VECS[i].exp_l, VECS[i].exp_r);
    end

    // R3 edge timing: not yet visible before the clock edge
    idle();
    l_addr = N; r_addr = N; r_we = 1'b1;
    @(posedge clk); #1;
    check("R3 visible after edge", l_irq_n, r_irq_n, 1'b0, 1'b1);
    idle();
    // R2 timing in same fashion
    l_addr = T; l_we = 1'b1;
    #0.5;
    check("R2 not before edge", l_irq_n, r_irq_n, 1'b0, 1'b1);
    @(posedge clk); #1;
    check("R2 visible after edge", l_irq_n, r_irq_n, 1'b0, 1'b0);
    idle();

    // R1 mid-run reset with both flags raised
    @(negedge clk);
    rst_n = 1'b0;
    #1;
    check("R1 async reset", l_irq_n, r_irq_n, 1'b1, 1'b1);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 stays idle", l_irq_n, r_irq_n, 1'b1, 1'b1);
    done = 1'b1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 2000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: run did not finish, actual timeout expected completion");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule